// File: doc/BRIEF.md
# Prefixed Instruction Group Sequencer

This block follows a run of instructions that share one 24-bit prefix. The prefix is detected upstream. It reaches the sequencer as a one-cycle strobe that carries two data-type codes, called type A and type B, and a base-register selector. From then on the sequencer takes 12-bit instruction units over a valid/ready stream. It splits them into group members. Each member is either one unit (register-to-register form) or two units (memory-reference form).

For every complete member the block presents one decoded record on a valid/ready output. The record holds:
- the 4-bit operation,
- the data type resolved from the prefix,
- the base-register selector from the prefix,
- the member length,
- a flag for the final member,
- the remaining operand bits.

After the final member the sequencer goes idle and stops accepting units, so the normal decoder takes the stream back. A prefix strobe that arrives while a group is open is treated as an error. It restarts the group with the new prefix.

Top module: `pfx_group_seq`

## Requirements
- R1: After a synchronous active-low reset, `grp_active`, `in_ready`, `out_valid` and `grp_err` are all 0.
- R2: A `pfx_stb` pulse captures `pfx_type_a`, `pfx_type_b` and `pfx_base`. In the next cycle `grp_active` is 1 and units can be accepted.
- R3: A first unit with bit 11 = 0 is a one-unit member. Its record has `out_long` = 0 and `out_fields` = {unit[4:0], 12'h000}, and it is valid in the cycle after the unit is accepted.
- R4: A first unit with bit 11 = 1 is a two-unit member. No record appears after the first unit alone. After the second unit is accepted, the record has `out_long` = 1 and `out_fields` = {first[4:0], second[11:0]}.
- R5: `out_op` equals bits 9:6 of the member's first unit.
- R6: `out_dtype` is the captured type A when bit 5 of the first unit is 0, and the captured type B when it is 1.
- R7: `out_base` equals the base selector captured from the prefix, for every member of the group.
- R8: Bit 10 of a member's first unit marks the final member and is reported as `out_last`. Once that member is accepted, `grp_active` and `in_ready` are 0 in the following cycle.
- R9: A `pfx_stb` while `grp_active` is 1 raises `grp_err` for exactly one cycle. It discards any half-received two-unit member, loads the new prefix fields and keeps the group open.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record is held unchanged and `in_ready` is 0. `in_ready` is also 0 in any cycle where `pfx_stb` is 1.
- R11: A `pfx_stb` while no group is open does not raise `grp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_stb | input | 1 | Prefix seen; fields below are valid |
| pfx_type_a | input | 4 | Data-type code used when the select bit is 0 |
| pfx_type_b | input | 4 | Data-type code used when the select bit is 1 |
| pfx_base | input | 1 | Base-register selector for memory-reference members |
| in_valid | input | 1 | Instruction unit offered |
| in_ready | output | 1 | Unit accepted this cycle when in_valid is also 1 |
| in_unit | input | 12 | Instruction unit |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Consumer takes the record |
| out_op | output | 4 | Operation code |
| out_dtype | output | 4 | Resolved data type |
| out_base | output | 1 | Base-register selector |
| out_long | output | 1 | 1 for a two-unit member |
| out_last | output | 1 | 1 for the final member of the group |
| out_fields | output | 17 | Operand bits: first[4:0] then second unit (zero for one-unit members) |
| grp_active | output | 1 | A group is open |
| grp_err | output | 1 | One-cycle pulse: prefix arrived inside an open group |

## Verification
The bench drives two-unit members and checks that no record leaks out after their first half. A design that emits early or drops the second unit would produce an extra or truncated record. It sends final members in both forms and then checks that the stream is released. A sequencer that keyed the end off the wrong unit would either stay open or hand units to nobody. A prefix is injected between the two halves of a member. This exposes a design that keeps the stale half or applies the old data types, and one that never flags the error. Long output stalls and randomly throttled consumers catch records that change or are overwritten while the consumer is not ready.

// File: rtl/pfx_seq_pkg.sv
// Shared constants and types for the prefixed instruction group sequencer.
// Assumes the first unit of a member is laid out, from the top bit down, as:
// form, final-flag, operation, type-select, then operand bits.
package pfx_seq_pkg;
    localparam int UNIT_W   = 12;
    localparam int OP_W     = 4;
    localparam int TYPE_W   = 4;
    localparam int BASE_W   = 1;
    localparam int FORM_BIT = UNIT_W - 1;
    localparam int LAST_BIT = UNIT_W - 2;
    localparam int OP_HI    = UNIT_W - 3;
    localparam int OP_LO    = OP_HI - OP_W + 1;
    localparam int SEL_BIT  = OP_LO - 1;
    localparam int REG_W    = SEL_BIT;
    localparam int FIELD_W  = REG_W + UNIT_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [TYPE_W-1:0] type_a;
        logic [TYPE_W-1:0] type_b;
        logic [BASE_W-1:0] base;
    } grp_ctx_t;

    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [TYPE_W-1:0]  dtype;
        logic [BASE_W-1:0]  base;
        logic               is_long;
        logic               is_last;
        logic [FIELD_W-1:0] fields;
    } member_t;
endpackage

// File: rtl/pfx_seq_ctrl.sv
// Group state machine and prefix context store.
// Does: tracks whether a group is open, whether the head of a two-unit member
// is being held, and which prefix fields apply. Emits one decode request for
// each complete member.
// Assumes: `space` is 1 when the output stage can take a record this cycle.
module pfx_seq_ctrl
    import pfx_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_stb,
    input  grp_ctx_t          pfx_ctx,
    input  logic              in_valid,
    input  logic [UNIT_W-1:0] in_unit,
    input  logic              space,
    output logic              in_ready,
    output logic              emit,
    output logic [UNIT_W-1:0] emit_head,
    output logic [UNIT_W-1:0] emit_tail,
    output grp_ctx_t          ctx,
    output logic              active,
    output logic              err
);
    seq_state_e        state_q;
    logic [UNIT_W-1:0] held_q;
    logic              take;
    logic              in_tail;

    // Accept units only inside a group, never alongside a prefix, and only with output space.
    always_comb begin
        active   = (state_q != ST_IDLE);
        in_tail  = (state_q == ST_TAIL);
        in_ready = active && !pfx_stb && space;
        take     = in_valid && in_ready;
    end

    // A member completes on its tail unit or on a one-unit head.
    always_comb begin
        emit      = take && (in_tail || !in_unit[FORM_BIT]);
        emit_head = in_tail ? held_q : in_unit;
        emit_tail = in_tail ? in_unit : '0;
    end

    // State, held head, prefix context and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
            ctx     <= '0;
            err     <= 1'b0;
        end else begin
            err <= 1'b0;
            if (pfx_stb) begin
                ctx     <= pfx_ctx;
                err     <= active;
                state_q <= ST_HEAD;
            end else if (take) begin
                if (!in_tail && in_unit[FORM_BIT]) begin
                    held_q  <= in_unit;
                    state_q <= ST_TAIL;
                end else if (emit_head[LAST_BIT]) begin
                    state_q <= ST_IDLE;
                end else begin
                    state_q <= ST_HEAD;
                end
            end
        end
    end

    AST_TAIL_HAS_LONG_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> held_q[FORM_BIT]); // R4
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && emit_head[LAST_BIT]) |=> !active); // R8
    AST_NO_TAKE_ON_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_stb |-> !in_ready); // R10
    AST_ERR_FROM_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(pfx_stb) && $past(active))); // R9
endmodule

// File: rtl/pfx_member_dec.sv
// Member decoder, purely combinational.
// Does: turns a head unit (plus a tail unit for two-unit members) and the
// prefix context into one decoded record.
// Assumes: tail is zero for one-unit members.
module pfx_member_dec
    import pfx_seq_pkg::*;
(
    input  logic [UNIT_W-1:0] head,
    input  logic [UNIT_W-1:0] tail,
    input  grp_ctx_t          ctx,
    output member_t           rec
);
    // Split the head fields and resolve the data type from the select bit.
    always_comb begin
        rec.op      = head[OP_HI:OP_LO];
        rec.dtype   = head[SEL_BIT] ? ctx.type_b : ctx.type_a;
        rec.base    = ctx.base;
        rec.is_long = head[FORM_BIT];
        rec.is_last = head[LAST_BIT];
        rec.fields  = {head[REG_W-1:0], tail};
    end
endmodule

// File: rtl/pfx_out_stage.sv
// Single-entry output register with a valid/ready handshake.
// Does: holds one decoded record until the consumer takes it.
// Assumes: load is only raised when space is 1.
module pfx_out_stage
    import pfx_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  member_t rec_in,
    input  logic    out_ready,
    output logic    space,
    output logic    out_valid,
    output member_t rec_out
);
    // The slot is free when empty or being drained this cycle.
    always_comb space = !out_valid || out_ready;

    // Hold or replace the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rec_out   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            rec_out   <= rec_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(rec_out))); // R10
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!out_valid || out_ready)); // R10
endmodule

// File: rtl/pfx_group_seq.sv
// Top of the prefixed instruction group sequencer.
// Does: joins the control, the decoder and the output stage.
// Assumes: prefix detection upstream presents a one-cycle strobe with its fields.
module pfx_group_seq
    import pfx_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pfx_stb,
    input  logic [TYPE_W-1:0]  pfx_type_a,
    input  logic [TYPE_W-1:0]  pfx_type_b,
    input  logic [BASE_W-1:0]  pfx_base,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [UNIT_W-1:0]  in_unit,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OP_W-1:0]    out_op,
    output logic [TYPE_W-1:0]  out_dtype,
    output logic [BASE_W-1:0]  out_base,
    output logic               out_long,
    output logic               out_last,
    output logic [FIELD_W-1:0] out_fields,
    output logic               grp_active,
    output logic               grp_err
);
    grp_ctx_t          pfx_ctx;
    grp_ctx_t          ctx;
    logic              space;
    logic              emit;
    logic [UNIT_W-1:0] emit_head;
    logic [UNIT_W-1:0] emit_tail;
    member_t           rec_new;
    member_t           rec_q;

    // Bundle the prefix fields.
    always_comb pfx_ctx = '{type_a: pfx_type_a, type_b: pfx_type_b, base: pfx_base};

    pfx_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfx_stb   (pfx_stb),
        .pfx_ctx   (pfx_ctx),
        .in_valid  (in_valid),
        .in_unit   (in_unit),
        .space     (space),
        .in_ready  (in_ready),
        .emit      (emit),
        .emit_head (emit_head),
        .emit_tail (emit_tail),
        .ctx       (ctx),
        .active    (grp_active),
        .err       (grp_err)
    );

    pfx_member_dec u_dec (
        .head (emit_head),
        .tail (emit_tail),
        .ctx  (ctx),
        .rec  (rec_new)
    );

    pfx_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit),
        .rec_in    (rec_new),
        .out_ready (out_ready),
        .space     (space),
        .out_valid (out_valid),
        .rec_out   (rec_q)
    );

    // Spread the held record onto the output ports.
    always_comb begin
        out_op     = rec_q.op;
        out_dtype  = rec_q.dtype;
        out_base   = rec_q.base;
        out_long   = rec_q.is_long;
        out_last   = rec_q.is_last;
        out_fields = rec_q.fields;
    end
endmodule

// File: tb/pfx_group_seq_bench.sv
// Scoreboard bench: member tasks push expected records, a monitor pops and compares.
module pfx_group_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_stb = 1'b0;
    logic [3:0]  pfx_type_a = '0;
    logic [3:0]  pfx_type_b = '0;
    logic [0:0]  pfx_base = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_unit = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  out_op;
    logic [3:0]  out_dtype;
    logic [0:0]  out_base;
    logic        out_long;
    logic        out_last;
    logic [16:0] out_fields;
    logic        grp_active;
    logic        grp_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic hold = 1'b0;
    logic stall_en = 1'b0;
    logic [3:0] ta = '0, tb = '0;
    logic       bs = 1'b0;
    logic [27:0] expq[$];

    pfx_group_seq u_pfx_group_seq (.*);

    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Consumer readiness, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        out_ready = hold ? 1'b0 : (stall_en ? (($urandom % 3) != 0) : 1'b1);
    end

    // Monitor: compare every transferred record with the queue head (R3..R8).
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected record", {4'h0, out_op, out_dtype, out_base, out_long, out_last, out_fields}, 32'h0);
            end else begin
                logic [27:0] e;
                e = expq.pop_front();
                chk({out_op, out_dtype, out_base, out_long, out_last, out_fields} == e,
                    "R3/R4/R5/R6/R7/R8 record", {4'h0, out_op, out_dtype, out_base, out_long, out_last, out_fields}, {4'h0, e});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL R10 watchdog: actual cycles=%0d expected below %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [27:0] exp_rec(input logic [11:0] h, input logic [11:0] t);
        return {h[9:6], (h[5] ? tb : ta), bs, h[11], h[10], h[4:0], (h[11] ? t : 12'h000)};
    endfunction

    task automatic send_unit(input logic [11:0] u);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_unit  = u;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic prefix(input logic [3:0] a, input logic [3:0] b, input logic base);
        logic was;
        @(posedge clk); #1;
        pfx_stb = 1'b1; pfx_type_a = a; pfx_type_b = b; pfx_base = base;
        @(negedge clk);
        was = grp_active;
        chk(!in_ready, "R10 no unit taken with prefix", in_ready, 0);
        @(posedge clk); #1;
        pfx_stb = 1'b0;
        ta = a; tb = b; bs = base;
        @(negedge clk);
        chk(grp_err == was, was ? "R9 error on mid-group prefix" : "R11 no error when idle", grp_err, was);
        chk(grp_active, "R2 group open after prefix", grp_active, 1);
        if (was) begin
            @(negedge clk);
            chk(!grp_err, "R9 error lasts one cycle", grp_err, 0);
        end
    endtask

    function automatic logic [11:0] head(input logic lng, input logic last, input logic [3:0] op,
                                         input logic sel, input logic [4:0] r);
        return {lng, last, op, sel, r};
    endfunction

    task automatic short_m(input logic last, input logic [3:0] op, input logic sel, input logic [4:0] r);
        logic [11:0] h;
        h = head(1'b0, last, op, sel, r);
        expq.push_back(exp_rec(h, 12'h0));
        send_unit(h);
    endtask

    task automatic long_m(input logic last, input logic [3:0] op, input logic sel, input logic [4:0] r,
                          input logic [11:0] t);
        logic [11:0] h;
        h = head(1'b1, last, op, sel, r);
        expq.push_back(exp_rec(h, t));
        send_unit(h);
        send_unit(t);
    endtask

    task automatic drain();
        repeat (20) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!grp_active, "R1 reset active", grp_active, 0);
        chk(!in_ready, "R1 reset in_ready", in_ready, 0);
        chk(!out_valid, "R1 reset out_valid", out_valid, 0);
        chk(!grp_err, "R1 reset err", grp_err, 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // Idle prefix, simple members (R2, R11, R3, R5, R6, R7)
        prefix(4'h3, 4'h9, 1'b1);
        short_m(1'b0, 4'hA, 1'b0, 5'h11);
        short_m(1'b0, 4'h5, 1'b1, 5'h0E);
        drain();
        // Two-unit member: nothing after its first half (R4)
        send_unit(head(1'b1, 1'b0, 4'h7, 1'b1, 5'h15));
        repeat (2) begin
            @(negedge clk);
            chk(!out_valid, "R4 no record after first half", out_valid, 0);
        end
        expq.push_back(exp_rec(head(1'b1, 1'b0, 4'h7, 1'b1, 5'h15), 12'hBCD));
        send_unit(12'hBCD);
        @(negedge clk);
        chk(out_valid || expq.size() == 0, "R4 record after second half", out_valid, 1);
        short_m(1'b1, 4'hF, 1'b0, 5'h01);
        @(negedge clk);
        chk(!grp_active, "R8 group closed after final short", grp_active, 0);
        chk(!in_ready, "R8 stream released", in_ready, 0);
        drain();

        // Final member in two-unit form (R8, R7 base 0)
        prefix(4'h5, 4'hC, 1'b0);
        short_m(1'b0, 4'h2, 1'b1, 5'h1F);
        long_m(1'b1, 4'h9, 1'b0, 5'h0A, 12'h123);
        @(negedge clk);
        chk(!grp_active, "R8 group closed after final long", grp_active, 0);
        drain();

        // Output stall (R10)
        hold = 1'b1;
        repeat (2) @(posedge clk);
        prefix(4'h1, 4'h2, 1'b1);
        short_m(1'b0, 4'h4, 1'b0, 5'h02);
        begin
            logic [27:0] snap;
            logic [11:0] h2;
            h2 = head(1'b0, 1'b1, 4'h6, 1'b1, 5'h03);
            expq.push_back(exp_rec(h2, 12'h0));
            @(posedge clk); #1;
            in_valid = 1'b1; in_unit = h2;
            @(negedge clk);
            snap = {out_op, out_dtype, out_base, out_long, out_last, out_fields};
            repeat (4) begin
                @(negedge clk);
                chk(!in_ready, "R10 input blocked while output full", in_ready, 0);
                chk(out_valid && ({out_op, out_dtype, out_base, out_long, out_last, out_fields} == snap),
                    "R10 record held", {4'h0, out_op, out_dtype, out_base, out_long, out_last, out_fields}, {4'h0, snap});
            end
            hold = 1'b0;
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #1;
            in_valid = 1'b0;
        end
        drain();

        // Prefix between the halves of a two-unit member (R9)
        prefix(4'h6, 4'h7, 1'b0);
        send_unit(head(1'b1, 1'b0, 4'h3, 1'b0, 5'h04));
        prefix(4'hD, 4'hE, 1'b1);
        short_m(1'b0, 4'h8, 1'b0, 5'h05);
        short_m(1'b1, 4'h8, 1'b1, 5'h06);
        drain();
        chk(expq.size() == 0, "R9 stale half discarded", expq.size(), 0);

        // Random groups under a throttled consumer (R3..R8)
        stall_en = 1'b1;
        for (int g = 0; g < 30; g++) begin
            prefix(4'($urandom), 4'($urandom), 1'($urandom));
            for (int m = 0; m < 6; m++) begin
                logic lst;
                lst = (m == 5);
                if ($urandom % 2)
                    long_m(lst, 4'($urandom), 1'($urandom), 5'($urandom), 12'($urandom));
                else
                    short_m(lst, 4'($urandom), 1'($urandom), 5'($urandom));
            end
            @(negedge clk);
            chk(!grp_active, "R8 closed after random group", grp_active, 0);
        end
        stall_en = 1'b0;
        drain();
        chk(expq.size() == 0, "R3 all records delivered", expq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule